// File: doc/BRIEF.md
# Indexed Pointer Address Generator

This block holds the index pointer of an 8-bit controller core and turns it into effective addresses for indexed memory accesses. The pointer is 12 bits wide. Its lower 11 bits are an ordinary address, counter or scratch value. Its top bit is a write-only selector that picks one of two memory segments: the data segment when it is 0, or the program segment when it is 1. The core changes the pointer in three ways. It can load all 12 bits at once with an immediate value. It can write the pointer as two halves over a small register bus, where the upper nibble sits at one bus address and the lower byte at another. It can also step the lower 11 bits up or down by one with a strobe.

Each indexed access enters on a valid/ready request channel and carries an 8-bit offset and a write flag. The block adds the offset to the lower 11 bits of the pointer. The segment bit passes straight through into the result. The result is held in a single output register and is offered on a valid/ready result channel, together with the segment flag and a write enable. The program segment is read-only, so a write aimed at it has its write enable removed and raises a one-cycle violation pulse.

Back-pressure works as follows. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the output register is empty, or is being emptied in that same cycle. While `res_valid` is high and `res_ready` is low, every result output stays frozen.

Top module: `idx_ptr_agen`

## Requirements
- R1: After reset the pointer is 0x000, `res_valid` is 0, `wr_viol` is 0 and `req_ready` is 1.
- R2: When `ld_en` is high at a clock edge, the pointer takes all 12 bits of `ld_val` from that edge on.
- R3: A bus write with `bus_we` high loads pointer bits 11:8 from `bus_wdata[3:0]` when `bus_addr` is 0xBE. It loads pointer bits 7:0 from `bus_wdata` when `bus_addr` is 0xBF. A bus write to any other address leaves the pointer unchanged.
- R4: `bus_rdata` follows `bus_addr` in the same cycle. At 0xBE it returns {5'b0, pointer[10:8]}, so bit 11 always reads back as 0. At 0xBF it returns pointer[7:0]. At any other address it returns 0x00.
- R5: For an accepted request, `res_addr` = {pointer[11], (pointer[10:0] + offset) mod 2^11}, using the pointer value held at the accepting edge. The result appears one cycle after acceptance.
- R6: `res_prog` equals bit 11 of `res_addr`. A value of 1 means the program segment and 0 means the data segment.
- R7: An accepted write whose pointer bit 11 is 1 presents `res_wr_en` = 0. It also drives `wr_viol` high for exactly the one cycle after acceptance. Writes to the data segment present `res_wr_en` = 1, reads present 0, and neither raises `wr_viol`.
- R8: An `inc` strobe adds 1 to pointer[10:0] and a `dec` strobe subtracts 1, wrapping modulo 2^11. Bit 11 is never changed by either. When both are high in the same cycle the pointer does not change.
- R9: Updates in the same cycle resolve by priority: the full load wins over a bus write, and a bus write wins over a step.
- R10: `req_ready` = !`res_valid` || `res_ready`. While `res_valid` is high and `res_ready` is low, `res_addr`, `res_prog` and `res_wr_en` stay stable. `res_valid` falls after a consuming edge when no new request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_en | input | 1 | Load the whole pointer from `ld_val` |
| ld_val | input | 12 | Immediate pointer value |
| inc | input | 1 | Step pointer[10:0] up by one |
| dec | input | 1 | Step pointer[10:0] down by one |
| bus_we | input | 1 | Register bus write strobe |
| bus_addr | input | 8 | Register bus address |
| bus_wdata | input | 8 | Register bus write data |
| bus_rdata | output | 8 | Register bus read data, combinational |
| req_valid | input | 1 | Indexed access request valid |
| req_ready | output | 1 | Request can be accepted |
| req_off | input | 8 | Offset added to the pointer |
| req_wr | input | 1 | Request is a write |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Downstream takes the result |
| res_addr | output | 12 | Effective address |
| res_prog | output | 1 | Result lies in the program segment |
| res_wr_en | output | 1 | Write permitted for this result |
| wr_viol | output | 1 | Pulse for a suppressed write to the program segment |

## Verification
Each output has a fixed delay, and the bench samples it at that delay. Pointer updates from a load, a bus write or a step become visible one edge later. They are observed through `bus_rdata`, which is combinational and is read one time unit after the address is set. Bit 11 cannot be read back over the bus, so it is observed through `res_addr` and `res_prog` on a later access. Access results and `wr_viol` are due on the first falling edge after the accepting rising edge. The violation pulse is checked again one edge later, to show that it has cleared. All inputs change on falling edges, so nothing depends on process order at the rising edge.

// File: rtl/idx_ptr_pkg.sv
package idx_ptr_pkg;
  parameter int PTR_W  = 12;
  parameter int OFF_W  = 8;
  parameter int BUS_AW = 8;
  parameter int BUS_DW = 8;
  localparam int LOW_W = PTR_W - 1;
  localparam int HI_W  = PTR_W - BUS_DW;
  localparam logic [BUS_AW-1:0] HI_ADDR = 8'hBE;
  localparam logic [BUS_AW-1:0] LO_ADDR = 8'hBF;
endpackage

// File: rtl/idx_ptr_reg.sv
module idx_ptr_reg
  import idx_ptr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [PTR_W-1:0]  ld_val,
  input  logic              hi_we,
  input  logic              lo_we,
  input  logic [BUS_DW-1:0] wdata,
  input  logic              inc,
  input  logic              dec,
  output logic [PTR_W-1:0]  ptr
);
  logic [PTR_W-1:0] ptr_q;
  logic [LOW_W-1:0] step;

  // Step value: +1, -1 (all ones) or 0 when both or neither strobe.
  always_comb begin
    step = '0;
    if (inc && !dec)      step = LOW_W'(1);
    else if (dec && !inc) step = '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ld_en) begin
      ptr_q <= ld_val;
    end else if (hi_we || lo_we) begin
      if (hi_we) ptr_q[PTR_W-1:BUS_DW] <= wdata[HI_W-1:0];
      if (lo_we) ptr_q[BUS_DW-1:0]     <= wdata;
    end else begin
      ptr_q[LOW_W-1:0] <= ptr_q[LOW_W-1:0] + step;
    end
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/idx_ptr_regbus.sv
module idx_ptr_regbus
  import idx_ptr_pkg::*;
(
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [PTR_W-1:0]  ptr,
  output logic              hi_we,
  output logic              lo_we,
  output logic [BUS_DW-1:0] rdata
);
  localparam int HI_RD_W = LOW_W - BUS_DW;

  logic hi_sel, lo_sel;
  logic [BUS_DW-1:0] hi_rd;

  assign hi_sel = (bus_addr == HI_ADDR);
  assign lo_sel = (bus_addr == LO_ADDR);
  assign hi_we  = bus_we && hi_sel;
  assign lo_we  = bus_we && lo_sel;

  // Segment bit is write-only: only pointer[10:8] is returned.
  always_comb begin
    hi_rd = '0;
    hi_rd[HI_RD_W-1:0] = ptr[LOW_W-1:BUS_DW];
  end

  always_comb begin
    if (hi_sel)      rdata = hi_rd;
    else if (lo_sel) rdata = ptr[BUS_DW-1:0];
    else             rdata = '0;
  end
endmodule

// File: rtl/idx_ptr_ea.sv
module idx_ptr_ea
  import idx_ptr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PTR_W-1:0] ptr,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [OFF_W-1:0] req_off,
  input  logic             req_wr,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [PTR_W-1:0] res_addr,
  output logic             res_wr_en,
  output logic             wr_viol
);
  logic             valid_q, wr_q, viol_q;
  logic [PTR_W-1:0] addr_q;
  logic             accept, seg;
  logic [LOW_W-1:0] low_sum;

  assign seg       = ptr[PTR_W-1];
  assign low_sum   = ptr[LOW_W-1:0] + LOW_W'(req_off);
  assign req_ready = !valid_q || res_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      wr_q    <= 1'b0;
      viol_q  <= 1'b0;
    end else begin
      viol_q <= accept && req_wr && seg;
      if (accept) begin
        valid_q <= 1'b1;
        addr_q  <= {seg, low_sum};
        wr_q    <= req_wr && !seg;
      end else if (res_ready) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign res_valid = valid_q;
  assign res_addr  = addr_q;
  assign res_wr_en = wr_q;
  assign wr_viol   = viol_q;
endmodule

// File: rtl/idx_ptr_agen.sv
module idx_ptr_agen
  import idx_ptr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [PTR_W-1:0]  ld_val,
  input  logic              inc,
  input  logic              dec,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [OFF_W-1:0]  req_off,
  input  logic              req_wr,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [PTR_W-1:0]  res_addr,
  output logic              res_prog,
  output logic              res_wr_en,
  output logic              wr_viol
);
  logic [PTR_W-1:0] ptr_q;
  logic             hi_we, lo_we;

  idx_ptr_regbus u_bus (
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .ptr      (ptr_q),
    .hi_we    (hi_we),
    .lo_we    (lo_we),
    .rdata    (bus_rdata)
  );

  idx_ptr_reg u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld_en  (ld_en),
    .ld_val (ld_val),
    .hi_we  (hi_we),
    .lo_we  (lo_we),
    .wdata  (bus_wdata),
    .inc    (inc),
    .dec    (dec),
    .ptr    (ptr_q)
  );

  idx_ptr_ea u_ea (
    .clk       (clk),
    .rst_n     (rst_n),
    .ptr       (ptr_q),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_off   (req_off),
    .req_wr    (req_wr),
    .res_valid (res_valid),
    .res_ready (res_ready),
    .res_addr  (res_addr),
    .res_wr_en (res_wr_en),
    .wr_viol   (wr_viol)
  );

  assign res_prog = res_addr[PTR_W-1];
endmodule

// File: rtl/idx_ptr_agen_chk.sv
module idx_ptr_agen_chk
  import idx_ptr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ld_en,
  input logic              inc,
  input logic              dec,
  input logic              bus_we,
  input logic [BUS_AW-1:0] bus_addr,
  input logic [BUS_DW-1:0] bus_rdata,
  input logic              res_valid,
  input logic              res_ready,
  input logic [PTR_W-1:0]  res_addr,
  input logic              res_prog,
  input logic              res_wr_en,
  input logic              wr_viol,
  input logic [PTR_W-1:0]  ptr_q
);
  logic bus_hit, inc_only;
  assign bus_hit  = bus_we && (bus_addr == HI_ADDR || bus_addr == LO_ADDR);
  assign inc_only = inc && !dec && !ld_en && !bus_hit;

  // R7
  viol_has_prog_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_viol |-> (res_valid && res_prog && !res_wr_en));

  // R7
  no_write_into_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_wr_en) |-> !res_prog);

  // R10
  stall_holds_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_addr) && $stable(res_wr_en)));

  // R8
  inc_keeps_segment_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc_only |=> (ptr_q[PTR_W-1] == $past(ptr_q[PTR_W-1])
                  && ptr_q[LOW_W-1:0] == $past(ptr_q[LOW_W-1:0]) + LOW_W'(1)));

  // R4
  hi_read_masks_segment_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == HI_ADDR) |-> (bus_rdata[BUS_DW-1:LOW_W-BUS_DW] == '0));
endmodule

bind idx_ptr_agen idx_ptr_agen_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ld_en     (ld_en),
  .inc       (inc),
  .dec       (dec),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_addr  (res_addr),
  .res_prog  (res_prog),
  .res_wr_en (res_wr_en),
  .wr_viol   (wr_viol),
  .ptr_q     (ptr_q)
);

// File: tb/idx_ptr_agen_tb.sv
module idx_ptr_agen_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_en = 1'b0;
  logic [11:0] ld_val = '0;
  logic        inc = 1'b0, dec = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = 8'h00, bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic        req_valid = 1'b0, req_ready;
  logic [7:0]  req_off = '0;
  logic        req_wr = 1'b0;
  logic        res_valid, res_ready = 1'b1;
  logic [11:0] res_addr;
  logic        res_prog, res_wr_en, wr_viol;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  idx_ptr_agen u_dut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_val(ld_val),
    .inc(inc), .dec(dec), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_off(req_off),
    .req_wr(req_wr), .res_valid(res_valid), .res_ready(res_ready),
    .res_addr(res_addr), .res_prog(res_prog), .res_wr_en(res_wr_en),
    .wr_viol(wr_viol)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [11:0] v);
    @(negedge clk); ld_en = 1'b1; ld_val = v;
    @(negedge clk); ld_en = 1'b0;
  endtask

  task automatic bwrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic bread(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic access(input logic [7:0] off, input logic wr);
    @(negedge clk); req_valid = 1'b1; req_off = off; req_wr = wr;
    @(negedge clk); req_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    bread(8'hBE, d); chk("R1 hi after reset", d, 8'h00);
    bread(8'hBF, d); chk("R1 lo after reset", d, 8'h00);
    chk("R1 res_valid", res_valid, 1'b0);
    chk("R1 wr_viol", wr_viol, 1'b0);
    chk("R1 req_ready", req_ready, 1'b1);
  endtask

  task automatic t_load;
    logic [7:0] d;
    load(12'h5A3);
    bread(8'hBE, d); chk("R2 hi after load", d, 8'h05);
    bread(8'hBF, d); chk("R2 lo after load", d, 8'hA3);
    load(12'hC12);
    bread(8'hBE, d); chk("R4 hi hides bit11", d, 8'h04);
    bread(8'h10, d); chk("R4 other addr reads 0", d, 8'h00);
    access(8'h10, 1'b0);
    chk("R2 bit11 loaded, addr", res_addr, 12'hC22);
    chk("R6 prog flag", res_prog, 1'b1);
    chk("R7 read no wr_en", res_wr_en, 1'b0);
    chk("R7 read no viol", wr_viol, 1'b0);
  endtask

  task automatic t_mmio;
    logic [7:0] d;
    bwrite(8'hBE, 8'hF3);
    bwrite(8'hBF, 8'h7E);
    bread(8'hBE, d); chk("R3 hi write", d, 8'h03);
    bread(8'hBF, d); chk("R3 lo write", d, 8'h7E);
    bwrite(8'h40, 8'hFF);
    bread(8'hBF, d); chk("R3 other addr ignored lo", d, 8'h7E);
    bread(8'hBE, d); chk("R3 other addr ignored hi", d, 8'h03);
    access(8'h00, 1'b0);
    chk("R3 bit11 cleared by hi write", res_addr, 12'h37E);
    chk("R6 data segment", res_prog, 1'b0);
  endtask

  task automatic t_data_write;
    load(12'h0F0);
    access(8'h20, 1'b1);
    chk("R5 data ea", res_addr, 12'h110);
    chk("R7 data write enabled", res_wr_en, 1'b1);
    chk("R7 data write no viol", wr_viol, 1'b0);
  endtask

  task automatic t_wrap;
    load(12'hFF0);
    access(8'h20, 1'b0);
    chk("R5 wrap keeps bit11", res_addr, 12'h810);
    chk("R6 wrap prog", res_prog, 1'b1);
    load(12'h7F0);
    access(8'h20, 1'b0);
    chk("R5 wrap data", res_addr, 12'h010);
  endtask

  task automatic t_viol;
    load(12'h805);
    access(8'h03, 1'b1);
    chk("R7 viol addr", res_addr, 12'h808);
    chk("R7 viol wr_en suppressed", res_wr_en, 1'b0);
    chk("R7 viol pulse", wr_viol, 1'b1);
    @(negedge clk);
    chk("R7 viol one cycle", wr_viol, 1'b0);
    chk("R10 valid drops", res_valid, 1'b0);
  endtask

  task automatic t_step;
    logic [7:0] d;
    load(12'h7FF);
    @(negedge clk); inc = 1'b1;
    @(negedge clk); inc = 1'b0;
    bread(8'hBF, d); chk("R8 inc wrap lo", d, 8'h00);
    access(8'h00, 1'b0);
    chk("R8 inc wrap keeps bit11", res_addr, 12'h000);
    load(12'h800);
    @(negedge clk); dec = 1'b1;
    @(negedge clk); dec = 1'b0;
    access(8'h00, 1'b0);
    chk("R8 dec wrap keeps bit11", res_addr, 12'hFFF);
    @(negedge clk); inc = 1'b1; dec = 1'b1;
    @(negedge clk); inc = 1'b0; dec = 1'b0;
    access(8'h00, 1'b0);
    chk("R8 inc+dec no change", res_addr, 12'hFFF);
  endtask

  task automatic t_priority;
    logic [7:0] d;
    load(12'h000);
    @(negedge clk);
    ld_en = 1'b1; ld_val = 12'h123; bus_we = 1'b1; bus_addr = 8'hBF;
    bus_wdata = 8'h55; inc = 1'b1;
    @(negedge clk);
    ld_en = 1'b0; bus_we = 1'b0; inc = 1'b0;
    bread(8'hBF, d); chk("R9 load beats bus and step", d, 8'h23);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 8'hBF; bus_wdata = 8'h55; inc = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; inc = 1'b0;
    bread(8'hBF, d); chk("R9 bus beats step", d, 8'h55);
    bread(8'hBE, d); chk("R9 bus beats step hi", d, 8'h01);
  endtask

  task automatic t_backpressure;
    load(12'h100);
    res_ready = 1'b0;
    access(8'h01, 1'b0);
    chk("R10 first result", res_addr, 12'h101);
    chk("R10 ready low when full", req_ready, 1'b0);
    req_valid = 1'b1; req_off = 8'h02; req_wr = 1'b0;
    @(negedge clk);
    chk("R10 held addr", res_addr, 12'h101);
    chk("R10 held valid", res_valid, 1'b1);
    res_ready = 1'b1;
    #1 chk("R10 ready follows res_ready", req_ready, 1'b1);
    @(negedge clk); req_valid = 1'b0;
    chk("R10 next result", res_addr, 12'h102);
    @(negedge clk);
    chk("R10 drains", res_valid, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_load();
    t_mmio();
    t_data_write();
    t_wrap();
    t_viol();
    t_step();
    t_priority();
    t_backpressure();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 5000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule